// File: doc/BRIEF.md
# Masked Interrupt Level Arbiter

This block merges the external interrupt level lines with the software interrupt register into one vector of pending levels, 1 to 15. Each cycle it picks the highest pending level that lies strictly above the processor interrupt level (`pil`). It holds the result as a trap type code for the core, where external interrupts occupy class 0x4, so level L becomes trap type 0x40 | L. The two timer bits of the software register do not map to levels of their own. Either one marks level 14 pending.

A small state machine tracks the request. In **IDLE** no request is raised. A new, different candidate moves it to **PEND** and raises `hard_req`. In PEND the block performs the final accept check. If the check passes it moves to **TAKE**, which lasts one cycle, drives the `take_trap` strobe, and then returns to IDLE. When the pending vector becomes empty, the state goes to IDLE and the stored trap type is cleared. The accept check depends on the architecture mode. In the newer mode the level must be above `pil`. In the older mode level 15 cannot be masked.

A candidate is not allowed to replace the stored trap type while a trap is already in progress (`trap_lvl` nonzero) whose own trap type (`cur_tt`) is greater than the candidate.

Top module: `irq_level_arb`

## Requirements
- R1: After reset, `pend_tt` is 0, `hard_req` is 0 and `take_trap` is 0.
- R2: Level L (1..15) is pending when `ext_lvl[L]` or `soft_reg[L]` is set. `ext_lvl[0]` is ignored and never creates a pending level.
- R3: `soft_reg[0]` (first timer) or `soft_reg[16]` (second timer) makes level 14 pending.
- R4: When no level is pending at a clock edge, `pend_tt` becomes 0 and `hard_req` drops after that edge, whatever the state.
- R5: With `irq_en` high, the candidate is the highest pending level L with L > `pil`. If the candidate differs from `pend_tt`, then after the next edge `pend_tt` = 0x40 | L and `hard_req` is 1. If no pending level lies above `pil`, nothing changes.
- R6: With `irq_en` low and some level pending, `pend_tt` and `hard_req` keep their values, and no trap is taken.
- R7: When `trap_lvl` is nonzero and `cur_tt` is greater than the candidate, `pend_tt` is not updated. If `cur_tt` is equal or smaller, the update proceeds.
- R8: `hard_req` is raised only when the candidate differs from the stored `pend_tt`. After a take, the same candidate does not raise it again.
- R9: In PEND, if `irq_en` is high, `pend_tt` is nonzero and the level check passes, `take_trap` is 1 for exactly the next cycle. `hard_req` is 0 during that cycle, and afterwards the block is back in IDLE.
- R10: The level check is done against the `pil` present at the accept edge. When `v8_mode` is 0 the level must be greater than `pil`. When `v8_mode` is 1, level 15 always passes and other levels must be greater than `pil`. Trap types outside class 0x4 skip the check.
- R11: `pend_tt` is held unchanged during the `take_trap` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl | input | 16 | External interrupt level lines, bit L = level L |
| soft_reg | input | 17 | Software interrupt register; bits 0 and 16 are timers |
| pil | input | 4 | Processor interrupt level |
| irq_en | input | 1 | Global interrupt enable |
| v8_mode | input | 1 | 1 = level 15 non-maskable at accept |
| trap_lvl | input | 3 | Current trap level |
| cur_tt | input | 9 | Trap type stored at the current trap level |
| pend_tt | output | 9 | Pending trap type, 0 when none |
| hard_req | output | 1 | Interrupt request to the core |
| take_trap | output | 1 | One-cycle strobe: trap accepted |

## Verification
The assertions assume that every input is synchronous to `clk` and settled before each rising edge, because the accept and clear checks relate outputs to input values sampled one edge earlier. They also assume that `soft_reg` has no bits beyond the two timer positions. The stimulus meets both assumptions by construction. Inputs change only on the falling edge. Random values are masked to the declared port widths. Input sets are held for one to four cycles, so that runs through PEND, TAKE and clearing actually occur.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_TAKE = 2'd2
    } arb_state_t;

    localparam int EXT_CLASS = 4;   // high nibble of external trap types
endpackage

// File: rtl/irq_fold.sv
module irq_fold #(
    parameter int NLVL      = 16,
    parameter int SOFT_W    = 17,
    parameter int TIMER_LVL = 14,
    parameter int STICK_BIT = 16
) (
    input  logic [NLVL-1:0]   ext_lvl,
    input  logic [SOFT_W-1:0] soft_reg,
    output logic [NLVL-1:0]   lvl_vec
);
    logic timer_hit;
    assign timer_hit  = soft_reg[0] | soft_reg[STICK_BIT];
    assign lvl_vec[0] = 1'b0;

    for (genvar g = 1; g < NLVL; g++) begin : g_lvl
        if (g == TIMER_LVL) begin : g_tmr
            assign lvl_vec[g] = ext_lvl[g] | soft_reg[g] | timer_hit;
        end else begin : g_pln
            assign lvl_vec[g] = ext_lvl[g] | soft_reg[g];
        end
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NLVL = 16,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] lvl_vec,
    input  logic [LW-1:0]   pil,
    output logic            found,
    output logic [LW-1:0]   lvl
);
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (lvl_vec[i] && (LW'(i) > pil)) begin
                found = 1'b1;
                lvl   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
    parameter int TT_W = 9,
    parameter int LW   = 4
) (
    input  logic [TT_W-1:0] pend_tt,
    input  logic [LW-1:0]   pil,
    input  logic            irq_en,
    input  logic            v8_mode,
    output logic            ok
);
    import irq_arb_pkg::*;

    localparam logic [LW-1:0] TOP_LVL = '1;

    logic          is_ext;
    logic [LW-1:0] lvl;
    logic          lvl_ok;

    assign is_ext = (pend_tt[TT_W-1:LW] == (TT_W-LW)'(EXT_CLASS));
    assign lvl    = pend_tt[LW-1:0];
    assign lvl_ok = v8_mode ? ((lvl == TOP_LVL) || (lvl > pil)) : (lvl > pil);
    assign ok     = irq_en && (pend_tt != '0) && (!is_ext || lvl_ok);
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
    parameter int NLVL   = 16,
    parameter int SOFT_W = 17,
    parameter int TT_W   = 9,
    parameter int TL_W   = 3,
    localparam int LW    = $clog2(NLVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLVL-1:0]   ext_lvl,
    input  logic [SOFT_W-1:0] soft_reg,
    input  logic [LW-1:0]     pil,
    input  logic              irq_en,
    input  logic              v8_mode,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [TT_W-1:0]   cur_tt,
    output logic [TT_W-1:0]   pend_tt,
    output logic              hard_req,
    output logic              take_trap
);
    import irq_arb_pkg::*;

    localparam logic [TT_W-1:0] EXT_BASE = TT_W'(EXT_CLASS << LW);

    arb_state_t      state_q, state_d;
    logic [TT_W-1:0] tt_q, tt_d;
    logic [NLVL-1:0] lvl_vec;
    logic            found, any_pend, blocked, upd, accept;
    logic [LW-1:0]   pick_lvl;
    logic [TT_W-1:0] cand;

    irq_fold #(.NLVL(NLVL), .SOFT_W(SOFT_W)) u_fold (
        .ext_lvl (ext_lvl),
        .soft_reg(soft_reg),
        .lvl_vec (lvl_vec)
    );

    irq_pick #(.NLVL(NLVL)) u_pick (
        .lvl_vec(lvl_vec),
        .pil    (pil),
        .found  (found),
        .lvl    (pick_lvl)
    );

    irq_accept #(.TT_W(TT_W), .LW(LW)) u_acc (
        .pend_tt(tt_q),
        .pil    (pil),
        .irq_en (irq_en),
        .v8_mode(v8_mode),
        .ok     (accept)
    );

    assign any_pend = |lvl_vec;
    assign cand     = EXT_BASE | TT_W'(pick_lvl);
    assign blocked  = (trap_lvl != '0) && (cur_tt > cand);
    assign upd      = irq_en && found && !blocked && (cand != tt_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tt_q    <= '0;
        end else begin
            state_q <= state_d;
            tt_q    <= tt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        tt_d    = tt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!any_pend) begin
                    tt_d = '0;
                end else if (upd) begin
                    tt_d    = cand;
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!any_pend) begin
                    tt_d    = '0;
                    state_d = ST_IDLE;
                end else if (accept) begin
                    state_d = ST_TAKE;
                end else if (upd) begin
                    tt_d = cand;
                end
            end
            ST_TAKE: begin
                state_d = ST_IDLE;
                if (!any_pend) tt_d = '0;
            end
            default: begin
                state_d = ST_IDLE;
                tt_d    = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        pend_tt   = tt_q;
        hard_req  = (state_q == ST_PEND);
        take_trap = (state_q == ST_TAKE);
    end
endmodule

module irq_level_arb_chk #(
    parameter int NLVL   = 16,
    parameter int SOFT_W = 17,
    parameter int TT_W   = 9,
    parameter int LW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLVL-1:0]   ext_lvl,
    input logic [SOFT_W-1:0] soft_reg,
    input logic [LW-1:0]     pil,
    input logic              v8_mode,
    input logic [TT_W-1:0]   pend_tt,
    input logic              hard_req,
    input logic              take_trap
);
    // R9
    take_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> $past(hard_req));
    // R9
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> !take_trap);
    // R9
    req_take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hard_req, take_trap}));
    // R4
    empty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(|ext_lvl[NLVL-1:1]) && !$past(|soft_reg)) |-> (pend_tt == '0 && !hard_req));
    // R10
    v9_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && !$past(v8_mode)) |-> ($past(pil) < pend_tt[LW-1:0]));
    // R11
    take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> $stable(pend_tt));
    // R5
    tt_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_tt != '0) |-> (pend_tt[TT_W-1:LW] == (TT_W-LW)'(4) && pend_tt[LW-1:0] != '0));
endmodule

bind irq_level_arb irq_level_arb_chk #(
    .NLVL(NLVL), .SOFT_W(SOFT_W), .TT_W(TT_W), .LW(LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_lvl  (ext_lvl),
    .soft_reg (soft_reg),
    .pil      (pil),
    .v8_mode  (v8_mode),
    .pend_tt  (pend_tt),
    .hard_req (hard_req),
    .take_trap(take_trap)
);

// File: tb/test_irq_level_arb.sv
module test_irq_level_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_lvl = '0;
    logic [16:0] soft_reg = '0;
    logic [3:0]  pil = '0;
    logic        irq_en = 1'b1;
    logic        v8_mode = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [8:0]  cur_tt = '0;
    logic [8:0]  pend_tt;
    logic        hard_req, take_trap;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_level_arb i_irq_level_arb (
        .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_reg(soft_reg),
        .pil(pil), .irq_en(irq_en), .v8_mode(v8_mode), .trap_lvl(trap_lvl),
        .cur_tt(cur_tt), .pend_tt(pend_tt), .hard_req(hard_req), .take_trap(take_trap)
    );

    // expected-value functions from the requirements
    function automatic logic [15:0] exp_levels(logic [15:0] e, logic [16:0] s);
        logic [15:0] v;
        v = (e | s[15:0]) & 16'hFFFE;
        if (s[0] || s[16]) v[14] = 1'b1;
        return v;
    endfunction

    function automatic int exp_pick(logic [15:0] v, logic [3:0] p);
        for (int i = 15; i > int'(p); i--) if (v[i]) return i;
        return 0;
    endfunction

    function automatic bit exp_accept(logic [8:0] tt, logic [3:0] p, bit en, bit v8);
        if (!en || tt == 0) return 0;
        if (tt[8:4] != 5'd4) return 1;
        if (v8 && tt[3:0] == 4'hF) return 1;
        return tt[3:0] > p;
    endfunction

    // reference state: 0 idle, 1 pending, 2 taking
    int         m_st;
    logic [8:0] m_tt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0;
            m_tt <= '0;
        end else begin
            logic [15:0] v;
            int          l;
            logic [8:0]  c;
            bit          u;
            v = exp_levels(ext_lvl, soft_reg);
            l = exp_pick(v, pil);
            c = 9'h40 | 9'(l);
            u = irq_en && l != 0 && !(trap_lvl != 0 && cur_tt > c) && c != m_tt;
            if (v == 0) begin
                m_st <= 0;
                m_tt <= '0;
            end else if (m_st == 0) begin
                if (u) begin m_st <= 1; m_tt <= c; end
            end else if (m_st == 1) begin
                if (exp_accept(m_tt, pil, irq_en, v8_mode)) m_st <= 2;
                else if (u) m_tt <= c;
            end else begin
                m_st <= 0;
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] outs();
        return {5'd0, take_trap, hard_req, pend_tt};
    endfunction

    function automatic logic [15:0] mk(bit t, bit h, logic [8:0] tt);
        return {5'd0, t, h, tt};
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic clear_all();
        ext_lvl = '0; soft_reg = '0; pil = '0; irq_en = 1'b1;
        v8_mode = 1'b0; trap_lvl = '0; cur_tt = '0;
        step(1);
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R5/R9 random", outs(), mk(m_st == 2, m_st == 1, m_tt));
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        check("R1 reset", outs(), mk(0, 0, 9'h0));

        ext_lvl = 16'h0001; step(2);
        check("R2 bit0 ignored", outs(), mk(0, 0, 9'h0));

        ext_lvl = 16'h0004; soft_reg = 17'h00080; step(1);
        check("R2 or of sources", outs(), mk(0, 1, 9'h47));
        step(2); clear_all();

        ext_lvl = 16'h0020; step(1);
        check("R5 select", outs(), mk(0, 1, 9'h45));
        step(1);
        check("R9 take strobe", outs(), mk(1, 0, 9'h45));
        check("R11 tt held", {7'd0, pend_tt}, 16'h0045);
        step(1);
        check("R9 back to idle", outs(), mk(0, 0, 9'h45));
        step(1);
        check("R8 no re-raise", outs(), mk(0, 0, 9'h45));

        soft_reg = 17'h00001; step(1);
        check("R3 tick to 14", outs(), mk(0, 1, 9'h4E));
        step(2);
        ext_lvl = '0; soft_reg = '0; step(1);
        check("R4 clear idle", outs(), mk(0, 0, 9'h0));

        ext_lvl = 16'h0008; step(1);
        ext_lvl = '0; step(1);
        check("R4 clear pending", outs(), mk(0, 0, 9'h0));

        soft_reg = 17'h10000; step(1);
        check("R3 stick to 14", outs(), mk(0, 1, 9'h4E));
        step(2); clear_all();

        irq_en = 1'b0; ext_lvl = 16'h0200; step(2);
        check("R6 disabled idle", outs(), mk(0, 0, 9'h0));
        irq_en = 1'b1; step(1);
        irq_en = 1'b0; ext_lvl = 16'h1200; step(1);
        check("R6 disabled hold", outs(), mk(0, 1, 9'h49));
        clear_all();

        pil = 4'd9; ext_lvl = 16'h0208; step(2);
        check("R5 none above pil", outs(), mk(0, 0, 9'h0));
        pil = 4'd8; step(1);
        check("R5 above pil", outs(), mk(0, 1, 9'h49));
        clear_all();

        ext_lvl = 16'h8000; step(1);
        pil = 4'd15; step(1);
        check("R10 v9 masks 15", outs(), mk(0, 1, 9'h4F));
        v8_mode = 1'b1; step(1);
        check("R10 v8 takes 15", outs(), mk(1, 0, 9'h4F));
        clear_all();

        trap_lvl = 3'd1; cur_tt = 9'h4A; ext_lvl = 16'h0020; step(1);
        check("R7 preempt blocked", outs(), mk(0, 0, 9'h0));
        cur_tt = 9'h45; step(1);
        check("R7 equal allowed", outs(), mk(0, 1, 9'h45));
        clear_all();

        do_reset();
        cmp_on = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            ext_lvl  = 16'($urandom & $urandom & $urandom);
            soft_reg = ($urandom % 4 == 0) ? 17'($urandom & $urandom & $urandom) : '0;
            pil      = 4'($urandom);
            irq_en   = ($urandom % 5) != 0;
            v8_mode  = ($urandom % 3) == 0;
            trap_lvl = ($urandom % 4 == 0) ? 3'($urandom) : 3'd0;
            cur_tt   = 9'h40 | 9'($urandom % 16);
            step(1 + int'($urandom % 4));
        end
        cmp_on = 1'b0;
        done = 1'b1;
        finish_run();
    end
endmodule